// File: doc/BRIEF.md
# Segmented Time-Division Bus Arbiter

This arbiter hands a shared bus to at most one of several processor masters, following a static time-division schedule that is held in a small internal table. The schedule covers one application period and is divided into segments. Each segment begins at a fixed period time and carries its own round: an ordered list of slots, each giving an owning master and a length in cycles. The round repeats from its first slot until the period counter reaches the start of the next segment. When the period ends, the schedule begins again at segment 0.

A master raises its request line and keeps it high. The grant follows in the same cycle whenever the current slot belongs to that master. Otherwise the request waits until the master's next owned slot begins. The last cycle of every slot is a guard cycle with no grant, so a transfer never runs past its slot. A slot whose owner is not requesting leaves the bus idle. Software loads the schedule through a write port while the arbiter is disabled. The loader refuses writes that would corrupt the active schedule or break the one-slot-per-master rule.

Top module: `tdma_bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle. A high bit belongs to the owner of the current slot, and that master's `req` is high in the same cycle.
- R2: A master that requests during another master's slot gets no grant until the first cycle of its own next slot. From that cycle on it is granted, in the same cycle, for as long as `req` stays high.
- R3: `gnt` is low on the final cycle of every slot. A slot of size 1 therefore never grants.
- R4: When the owner of the current slot is not requesting, `gnt` is all zero for that cycle, even if other masters are requesting.
- R5: Within a segment, the slot after the round's last slot (index = the stored last-slot index) is slot 0 of the same round.
- R6: The first cycle whose period time equals the start time of the next segment (next index not above the stored last segment) uses slot 0, cycle 0 of that segment. This holds even if the previous round was left part-way through.
- R7: The period time counts 0 to period length − 1 and then returns to 0, which restarts segment 0 at slot 0. When `period_start` is high in an enabled cycle, the next cycle is period time 0.
- R8: While `arb_en` is low, `gnt` is all zero and the schedule position is held at period time 0. The first enabled cycle is therefore segment 0, slot 0, cycle 0.
- R9: The `cfg_op` codes are: 0 = segment header (`cfg_seg`, start = `cfg_time`, last slot index = `cfg_slot`); 1 = slot entry (`cfg_seg`, `cfg_slot`, `cfg_owner`, `cfg_size`); 2 = period (length = `cfg_time`, last segment index = `cfg_seg`); 3 is invalid. A write while `arb_en` is high, or with code 3, is rejected. A rejected write raises `cfg_err` for exactly the following cycle and changes no table contents.
- R10: A slot write is rejected, with `cfg_err` raised the next cycle, if `cfg_size` is 0 or if `cfg_owner` already owns a lower-indexed slot of the same segment.
- R11: After reset, `gnt` and `cfg_err` are 0. Every segment starts at 0 with one slot. Every slot is owned by master 0 with size 1. The period length is 2^TIME_W − 1 and the last segment index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arb_en | input | 1 | Run the schedule; low holds the arbiter idle and opens the table to writes |
| period_start | input | 1 | Restart the period at time 0 in the next cycle |
| req | input | N_MST | Per-master bus request |
| gnt | output | N_MST | Per-master bus grant, at most one high |
| cfg_we | input | 1 | Table write strobe |
| cfg_op | input | 2 | Write kind (header, slot, period, invalid) |
| cfg_seg | input | log2(N_SEG) | Segment index, or last segment index for a period write |
| cfg_slot | input | log2(N_SLOT) | Slot index, or last slot index for a header write |
| cfg_time | input | TIME_W | Segment start time or period length |
| cfg_owner | input | log2(N_MST) | Slot owner |
| cfg_size | input | SIZE_W | Slot length in cycles |
| cfg_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The grant is a combinational function of the registered schedule position and the present `req`. The bench therefore checks `gnt` mid-cycle, after it has set `req` for that cycle. It checks `cfg_err` one cycle after the write that caused it, just after the rising edge. Moves between slots, segments and periods take effect in the cycle after the counter condition that triggers them. The behavioural model advances its own position only at that edge, so every grant is compared against the slot that is in force in that cycle. Because the position is compared every cycle, a rejected write that altered the table would show up as a later grant mismatch.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        OP_HDR    = 2'd0,
        OP_SLOT   = 2'd1,
        OP_PERIOD = 2'd2,
        OP_BAD    = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic live;
        logic bad_op;
        logic zero_size;
        logic dup_owner;
    } cfg_fault_t;

    function automatic logic fault_any(cfg_fault_t f);
        return f.live | f.bad_op | f.zero_size | f.dup_owner;
    endfunction

endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table
    import tdma_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int N_SEG  = 16,
    parameter int N_SLOT = 4,
    parameter int TIME_W = 12,
    parameter int SIZE_W = 6,
    localparam int OWN_W  = (N_MST  > 1) ? $clog2(N_MST)  : 1,
    localparam int SEG_W  = (N_SEG  > 1) ? $clog2(N_SEG)  : 1,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              live,
    input  logic              cfg_we,
    input  cfg_op_e           cfg_op,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [TIME_W-1:0] cfg_time,
    input  logic [OWN_W-1:0]  cfg_owner,
    input  logic [SIZE_W-1:0] cfg_size,
    output logic              cfg_err,
    input  logic [SEG_W-1:0]  rd_seg,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [SEG_W-1:0]  rd_seg_nxt,
    output logic [OWN_W-1:0]  rd_owner,
    output logic [SIZE_W-1:0] rd_size,
    output logic [SLOT_W-1:0] rd_last_slot,
    output logic [TIME_W-1:0] rd_nxt_start,
    output logic [TIME_W-1:0] period_len,
    output logic [SEG_W-1:0]  last_seg
);

    logic [TIME_W-1:0] seg_start  [N_SEG];
    logic [SLOT_W-1:0] seg_last   [N_SEG];
    logic [OWN_W-1:0]  slot_owner [N_SEG][N_SLOT];
    logic [SIZE_W-1:0] slot_size  [N_SEG][N_SLOT];

    logic [N_SLOT-1:0] dup_hit;
    cfg_fault_t        fault;
    logic              reject;

    // One comparator per slot position: same owner in an earlier slot of the round
    for (genvar j = 0; j < N_SLOT; j++) begin : g_dup
        assign dup_hit[j] = (SLOT_W'(j) < cfg_slot) &&
                            (slot_owner[cfg_seg][j] == cfg_owner);
    end

    always_comb begin
        fault.live      = live;
        fault.bad_op    = (cfg_op == OP_BAD);
        fault.zero_size = (cfg_op == OP_SLOT) && (cfg_size == '0);
        fault.dup_owner = (cfg_op == OP_SLOT) && (|dup_hit);
        reject          = fault_any(fault);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err    <= 1'b0;
            period_len <= '1;
            last_seg   <= '0;
            for (int s = 0; s < N_SEG; s++) begin
                seg_start[s] <= '0;
                seg_last[s]  <= '0;
                for (int k = 0; k < N_SLOT; k++) begin
                    slot_owner[s][k] <= '0;
                    slot_size[s][k]  <= SIZE_W'(1);
                end
            end
        end else begin
            cfg_err <= cfg_we && reject;
            if (cfg_we && !reject) begin
                case (cfg_op)
                    OP_HDR: begin
                        seg_start[cfg_seg] <= cfg_time;
                        seg_last[cfg_seg]  <= cfg_slot;
                    end
                    OP_SLOT: begin
                        slot_owner[cfg_seg][cfg_slot] <= cfg_owner;
                        slot_size[cfg_seg][cfg_slot]  <= cfg_size;
                    end
                    OP_PERIOD: begin
                        period_len <= cfg_time;
                        last_seg   <= cfg_seg;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_owner     = slot_owner[rd_seg][rd_slot];
    assign rd_size      = slot_size[rd_seg][rd_slot];
    assign rd_last_slot = seg_last[rd_seg];
    assign rd_nxt_start = seg_start[rd_seg_nxt];

endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer #(
    parameter int N_SEG  = 16,
    parameter int N_SLOT = 4,
    parameter int TIME_W = 12,
    parameter int SIZE_W = 6,
    localparam int SEG_W  = (N_SEG  > 1) ? $clog2(N_SEG)  : 1,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [SIZE_W-1:0] cur_size,
    input  logic [SLOT_W-1:0] cur_last_slot,
    input  logic [TIME_W-1:0] nxt_start,
    input  logic [TIME_W-1:0] period_len,
    input  logic [SEG_W-1:0]  last_seg,
    output logic [TIME_W-1:0] pc,
    output logic [SEG_W-1:0]  seg,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_final
);

    typedef struct packed {
        logic [TIME_W-1:0] pc;
        logic [SEG_W-1:0]  seg;
        logic [SLOT_W-1:0] slot;
        logic [SIZE_W-1:0] cnt;
    } pos_t;

    pos_t              st_q, st_d;
    logic [TIME_W-1:0] pc_inc;
    logic              wrap;
    logic              seg_hit;

    always_comb begin
        slot_final = (st_q.cnt == cur_size - SIZE_W'(1));
        wrap       = (st_q.pc == period_len - TIME_W'(1));
        pc_inc     = wrap ? '0 : st_q.pc + TIME_W'(1);
        seg_hit    = (st_q.seg != last_seg) && (pc_inc == nxt_start);

        st_d = st_q;
        if (!run || restart || wrap) begin
            st_d = '0;
        end else if (seg_hit) begin
            st_d.pc   = pc_inc;
            st_d.seg  = st_q.seg + SEG_W'(1);
            st_d.slot = '0;
            st_d.cnt  = '0;
        end else if (slot_final) begin
            st_d.pc   = pc_inc;
            st_d.slot = (st_q.slot == cur_last_slot) ? '0 : st_q.slot + SLOT_W'(1);
            st_d.cnt  = '0;
        end else begin
            st_d.pc  = pc_inc;
            st_d.cnt = st_q.cnt + SIZE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc   = st_q.pc;
    assign seg  = st_q.seg;
    assign slot = st_q.slot;

endmodule

// File: rtl/tdma_grant.sv
module tdma_grant #(
    parameter int N_MST = 4,
    localparam int OWN_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             run,
    input  logic             guard,
    input  logic [N_MST-1:0] req,
    input  logic [OWN_W-1:0] owner,
    output logic [N_MST-1:0] gnt
);

    for (genvar i = 0; i < N_MST; i++) begin : g_line
        assign gnt[i] = run && !guard && req[i] && (owner == OWN_W'(i));
    end

endmodule

// File: rtl/tdma_bus_arbiter.sv
module tdma_bus_arbiter
    import tdma_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int N_SEG  = 16,
    parameter int N_SLOT = 4,
    parameter int TIME_W = 12,
    parameter int SIZE_W = 6,
    localparam int OWN_W  = (N_MST  > 1) ? $clog2(N_MST)  : 1,
    localparam int SEG_W  = (N_SEG  > 1) ? $clog2(N_SEG)  : 1,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arb_en,
    input  logic              period_start,
    input  logic [N_MST-1:0]  req,
    output logic [N_MST-1:0]  gnt,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_op,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [TIME_W-1:0] cfg_time,
    input  logic [OWN_W-1:0]  cfg_owner,
    input  logic [SIZE_W-1:0] cfg_size,
    output logic              cfg_err
);

    logic [TIME_W-1:0] pc_w;
    logic [SEG_W-1:0]  seg_w;
    logic [SLOT_W-1:0] slot_w;
    logic              final_w;
    logic [OWN_W-1:0]  owner_w;
    logic [SIZE_W-1:0] size_w;
    logic [SLOT_W-1:0] last_slot_w;
    logic [TIME_W-1:0] nxt_start_w;
    logic [TIME_W-1:0] period_len_w;
    logic [SEG_W-1:0]  last_seg_w;

    tdma_sched_table #(
        .N_MST(N_MST), .N_SEG(N_SEG), .N_SLOT(N_SLOT),
        .TIME_W(TIME_W), .SIZE_W(SIZE_W)
    ) u_table (
        .clk          (clk),
        .rst          (rst),
        .live         (arb_en),
        .cfg_we       (cfg_we),
        .cfg_op       (cfg_op_e'(cfg_op)),
        .cfg_seg      (cfg_seg),
        .cfg_slot     (cfg_slot),
        .cfg_time     (cfg_time),
        .cfg_owner    (cfg_owner),
        .cfg_size     (cfg_size),
        .cfg_err      (cfg_err),
        .rd_seg       (seg_w),
        .rd_slot      (slot_w),
        .rd_seg_nxt   (seg_w + SEG_W'(1)),
        .rd_owner     (owner_w),
        .rd_size      (size_w),
        .rd_last_slot (last_slot_w),
        .rd_nxt_start (nxt_start_w),
        .period_len   (period_len_w),
        .last_seg     (last_seg_w)
    );

    tdma_sequencer #(
        .N_SEG(N_SEG), .N_SLOT(N_SLOT), .TIME_W(TIME_W), .SIZE_W(SIZE_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .run           (arb_en),
        .restart       (period_start),
        .cur_size      (size_w),
        .cur_last_slot (last_slot_w),
        .nxt_start     (nxt_start_w),
        .period_len    (period_len_w),
        .last_seg      (last_seg_w),
        .pc            (pc_w),
        .seg           (seg_w),
        .slot          (slot_w),
        .slot_final    (final_w)
    );

    tdma_grant #(.N_MST(N_MST)) u_gnt (
        .run   (arb_en),
        .guard (final_w),
        .req   (req),
        .owner (owner_w),
        .gnt   (gnt)
    );

endmodule

// File: rtl/tdma_bus_arbiter_chk.sv
module tdma_bus_arbiter_chk #(
    parameter int N_MST  = 4,
    parameter int TIME_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              arb_en,
    input logic              period_start,
    input logic [N_MST-1:0]  req,
    input logic [N_MST-1:0]  gnt,
    input logic              cfg_we,
    input logic              cfg_err,
    input logic [TIME_W-1:0] pc,
    input logic [TIME_W-1:0] period_len
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R1

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R1

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        !arb_en |-> (gnt == '0)); // R8

    AST_IDLE_HOLDS_TIME: assert property (@(posedge clk) disable iff (rst)
        !arb_en |=> (pc == '0)); // R8

    AST_LIVE_WRITE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (arb_en && cfg_we) |=> cfg_err); // R9

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> !cfg_err); // R9

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (arb_en && (pc == period_len - TIME_W'(1))) |=> (pc == '0)); // R7

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (arb_en && period_start) |=> (pc == '0)); // R7

endmodule

bind tdma_bus_arbiter tdma_bus_arbiter_chk #(.N_MST(N_MST), .TIME_W(TIME_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .arb_en       (arb_en),
    .period_start (period_start),
    .req          (req),
    .gnt          (gnt),
    .cfg_we       (cfg_we),
    .cfg_err      (cfg_err),
    .pc           (pc_w),
    .period_len   (period_len_w)
);

// File: tb/sim_tdma_bus_arbiter.sv
`timescale 1ns/1ps
module sim_tdma_bus_arbiter;

    localparam int NM = 4, NS = 16, NL = 4, TW = 12, SW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arb_en = 1'b0;
    logic          period_start = 1'b0;
    logic [NM-1:0] req = '0;
    logic [NM-1:0] gnt;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [3:0]    cfg_seg = '0;
    logic [1:0]    cfg_slot = '0;
    logic [TW-1:0] cfg_time = '0;
    logic [1:0]    cfg_owner = '0;
    logic [SW-1:0] cfg_size = '0;
    logic          cfg_err;

    int checks = 0, errors = 0;
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    // Behavioural model state
    int m_start [NS];
    int m_last  [NS];
    int m_own   [NS][NL];
    int m_size  [NS][NL];
    int m_plen, m_lseg;
    int pc, seg, sl, cnt;

    always #5 clk = ~clk;

    tdma_bus_arbiter u0 (
        .clk(clk), .rst(rst), .arb_en(arb_en), .period_start(period_start),
        .req(req), .gnt(gnt), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_seg(cfg_seg), .cfg_slot(cfg_slot), .cfg_time(cfg_time),
        .cfg_owner(cfg_owner), .cfg_size(cfg_size), .cfg_err(cfg_err)
    );

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_start[s] = 0;
            m_last[s]  = 0;
            for (int k = 0; k < NL; k++) begin
                m_own[s][k]  = 0;
                m_size[s][k] = 1;
            end
        end
        m_plen = (1 << TW) - 1;
        m_lseg = 0;
        pc = 0; seg = 0; sl = 0; cnt = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: set inputs before, check gnt mid-cycle, check cfg_err after the edge
    task automatic step();
        int eg, own, npc, nseg, nsl, ncnt;
        bit rej, dup;
        string tag, etag;
        if (rmode == 1) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req  = lfsr[3:0];
        end
        #2;
        own = m_own[seg][sl];
        eg  = (arb_en && !rst && cnt != m_size[seg][sl] - 1 && req[own]) ? (1 << own) : 0;
        if (rst)                                        tag = "R11";
        else if (!arb_en)                               tag = "R8";
        else if (cnt == m_size[seg][sl] - 1)            tag = "R3";
        else if (!req[own])                             tag = "R4";
        else if (pc == 0)                               tag = "R7";
        else if (cnt == 0 && sl == 0 && pc == m_start[seg] && seg > 0) tag = "R6";
        else if (cnt == 0 && sl == 0)                   tag = "R5";
        else if (cnt == 0)                              tag = "R2";
        else                                            tag = "R1";
        chk(gnt === NM'(eg), tag, int'(gnt), eg);

        // expected rejection
        dup = 0;
        if (cfg_op == 2'd1)
            for (int j = 0; j < NL; j++)
                if (j < int'(cfg_slot) && m_own[cfg_seg][j] == int'(cfg_owner)) dup = 1;
        rej  = arb_en || cfg_op == 2'd3 || (cfg_op == 2'd1 && (cfg_size == 0 || dup));
        etag = (cfg_op == 2'd1 && !arb_en && (cfg_size == 0 || dup)) ? "R10" : "R9";

        // expected next position
        npc = (pc == m_plen - 1) ? 0 : pc + 1;
        nseg = seg; nsl = sl; ncnt = cnt;
        if (!arb_en || period_start || npc == 0) begin
            npc = 0; nseg = 0; nsl = 0; ncnt = 0;
        end else if (seg != m_lseg && npc == m_start[seg + 1]) begin
            nseg = seg + 1; nsl = 0; ncnt = 0;
        end else if (cnt == m_size[seg][sl] - 1) begin
            ncnt = 0; nsl = (sl == m_last[seg]) ? 0 : sl + 1;
        end else begin
            ncnt = cnt + 1;
        end

        @(posedge clk);
        #1;
        if (rst) begin
            model_reset();
            chk(cfg_err === 1'b0, "R11", int'(cfg_err), 0);
        end else begin
            chk(cfg_err === (cfg_we && rej), etag, int'(cfg_err), int'(cfg_we && rej));
            if (cfg_we && !rej) begin
                case (cfg_op)
                    2'd0: begin m_start[cfg_seg] = cfg_time; m_last[cfg_seg] = cfg_slot; end
                    2'd1: begin m_own[cfg_seg][cfg_slot] = cfg_owner; m_size[cfg_seg][cfg_slot] = cfg_size; end
                    2'd2: begin m_plen = cfg_time; m_lseg = cfg_seg; end
                    default: ;
                endcase
            end
            pc = npc; seg = nseg; sl = nsl; cnt = ncnt;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input int op, input int sg, input int st, input int tm,
                      input int ow, input int sz);
        cfg_we = 1'b1; cfg_op = 2'(op); cfg_seg = 4'(sg); cfg_slot = 2'(st);
        cfg_time = TW'(tm); cfg_owner = 2'(ow); cfg_size = SW'(sz);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        model_reset();
        @(negedge clk);
        req = '1;
        run(3);                       // R11: no grant, no error in reset
        rst = 1'b0;

        // R11: default table has size-1 slots, so no grant ever
        arb_en = 1'b1;
        run(20);
        // R9: writes while running are refused
        wr(0, 1, 1, 60, 0, 0);
        wr(1, 0, 0, 0, 2, 5);
        arb_en = 1'b0;
        run(3);

        // Two-segment schedule, period 100
        wr(2, 1, 0, 100, 0, 0);
        wr(0, 0, 1, 0, 0, 0);
        wr(1, 0, 0, 0, 0, 10);
        wr(1, 0, 1, 0, 1, 20);
        wr(0, 1, 1, 60, 0, 0);
        wr(1, 1, 0, 0, 0, 10);
        wr(1, 1, 1, 0, 1, 10);
        // R10: duplicate owner and zero size; R9: invalid code
        wr(1, 1, 1, 0, 0, 7);
        wr(1, 1, 1, 0, 2, 0);
        wr(3, 0, 0, 0, 0, 0);

        arb_en = 1'b1;
        req = 4'b0011; run(250);
        req = 4'b0010; run(100);
        req = 4'b0100; run(40);       // R4: non-owner requests only
        rmode = 1;     run(300);
        period_start = 1'b1; step(); period_start = 1'b0;   // R7
        run(80);
        wr(2, 0, 0, 30, 0, 0);        // R9: refused while live
        run(40);
        rmode = 0;

        // Three-segment schedule, period 50, with a size-1 slot and mid-round switch
        arb_en = 1'b0;
        run(2);
        wr(2, 2, 0, 50, 0, 0);
        wr(0, 0, 2, 0, 0, 0);
        wr(1, 0, 0, 0, 2, 5);
        wr(1, 0, 1, 0, 0, 3);
        wr(1, 0, 2, 0, 3, 1);
        wr(0, 1, 0, 17, 0, 0);
        wr(1, 1, 0, 0, 1, 4);
        wr(0, 2, 1, 30, 0, 0);
        wr(1, 2, 0, 0, 3, 6);
        wr(1, 2, 1, 0, 2, 2);
        arb_en = 1'b1;
        req = '1;  run(120);
        rmode = 1; run(200);
        rmode = 0;
        arb_en = 1'b0; req = '1; run(5);   // R8
        arb_en = 1'b1; run(30);

        finish_up();
    end

endmodule